// File: doc/BRIEF.md
# Character LCD Init and Display Sequencer

This block drives a 16-column, two-row character LCD that is wired through a 4-bit data bus. It never touches the panel pins itself. Instead it hands every command or character byte to a separate nibble-write engine. It uses a start pulse for each byte and waits for the engine's done pulse before it goes on. After reset it lets the panel power up, then runs the fixed initialisation commands and comes to rest in an idle state.

From idle, push-button inputs drive it. The write button sets the display address to the start of the chosen row and then sends sixteen characters, one per column. The characters come from one of two fixed strings, held as parameters. The clear button sends a single clear-display command. Two level inputs choose the target row and the string. Every wait is counted in clock cycles, and the defaults are derived from the clock rate in kHz. If the clock changes, only that one number needs to change.

Top module: `lcd_seq`

## Requirements
- R1: `rst_n` is asynchronous and active low. While it is low, `wr_start` stays 0. After release, the first `wr_start` comes exactly `PWRUP_CYC` clock edges after the release, and never earlier.
- R2: The initialisation consists of nine commands, all with `wr_rs`=0, in this order. First come four single-nibble writes of 0x3, 0x3, 0x3 and 0x2; for these `wr_nib`=1, the nibble is in `wr_byte[7:4]` and `wr_byte[3:0]`=0. Then come five full-byte writes (`wr_nib`=0): 0x28, 0x0C, 0x06, 0x01 and 0x02.
- R3: The block counts the cycle in which `wr_done` is sampled high as cycle c. The next `wr_start` is seen in cycle c+N+1. N is `LONG_CYC` after a 0x01 or 0x02 command and `CMD_CYC` after any other command or character.
- R4: In idle, `btn_write` starts a row write: an address command (`wr_rs`=0) of 0x80 when `sel_row2`=0 or 0xC0 when `sel_row2`=1, followed by sixteen data writes (`wr_rs`=1, `wr_nib`=0), after which the block returns to idle. The first data write is column 0, which takes the most significant byte of the string.
- R5: `sel_text`=0 selects `TEXT_A` and 1 selects `TEXT_B`. Both `sel_text` and `sel_row2` are captured in the cycle the write button is accepted, and later changes do not alter the sequence in progress.
- R6: In idle, `btn_clear` sends one command 0x01 (`wr_rs`=0, `wr_nib`=0) and then returns to idle. If both buttons are high in the same idle cycle, the clear is taken and no row write follows.
- R7: `wr_start` is high for exactly one cycle per command, and `wr_byte`/`wr_rs`/`wr_nib` hold steady until `wr_done`. A `wr_done` pulse while no command is outstanding causes no command.
- R8: The buttons have no effect unless the block is idle. Pressing them during a row write adds no command.
- R9: Asserting `rst_n` in the middle of any sequence abandons it and restarts from the power-up wait and the first initialisation nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_clear | input | 1 | Clear-screen request, sampled in idle |
| btn_write | input | 1 | Start writing the chosen string to the chosen row |
| sel_row2 | input | 1 | Target row: 0 first row, 1 second row |
| sel_text | input | 1 | String choice: 0 `TEXT_A`, 1 `TEXT_B` |
| wr_done | input | 1 | Write engine finished the current byte |
| wr_start | output | 1 | One-cycle request to the write engine |
| wr_byte | output | 8 | Command or character byte |
| wr_rs | output | 1 | 0 command register, 1 data register |
| wr_nib | output | 1 | 1 send only the upper nibble of `wr_byte` |

## Verification
Almost every fault in the state register, step index or column counter changes the command stream, and this shows up at the next `wr_start`. The symptom is a wrong byte, a wrong register select, a skipped or repeated column, or a stray command in idle. A fault in the shared delay counter shows up as a start that comes too early or too late by a measurable number of cycles. It can be seen on the first command issued after the fault. A handshake fault either stalls the stream, which the bench catches with a per-command timeout, or changes `wr_byte` while the engine is still working.

// File: rtl/lcd_seq.sv
module lcd_seq #(
  parameter int CLK_KHZ   = 33000,
  parameter int PWRUP_CYC = CLK_KHZ * 15,
  parameter int CMD_CYC   = (CLK_KHZ * 40 + 999) / 1000,
  parameter int LONG_CYC  = (CLK_KHZ * 164 + 99) / 100,
  parameter int COLS      = 16,
  parameter logic [COLS*8-1:0] TEXT_A = "READY           ",
  parameter logic [COLS*8-1:0] TEXT_B = "STANDBY MODE    "
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_clear,
  input  logic       btn_write,
  input  logic       sel_row2,
  input  logic       sel_text,
  input  logic       wr_done,
  output logic       wr_start,
  output logic [7:0] wr_byte,
  output logic       wr_rs,
  output logic       wr_nib
);
  localparam int MAXA = (PWRUP_CYC > LONG_CYC) ? PWRUP_CYC : LONG_CYC;
  localparam int MAXC = (MAXA > CMD_CYC) ? MAXA : CMD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int COLW = $clog2(COLS);
  localparam logic [3:0] LAST_INIT = 4'd8;

  typedef enum logic [2:0] {S_PWR, S_INIT, S_IDLE, S_ADDR, S_CHAR, S_CLR} st_t;
  typedef enum logic [1:0] {P_GO, P_ACK, P_EXEC} ph_t;

  st_t             st;
  ph_t             ph;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   exec_len;
  logic [3:0]      step;
  logic [COLW-1:0] col;
  logic            row2_q, txt_b_q;
  logic [7:0]      cur_char;
  logic            issuing;

  function automatic logic [8:0] init_cmd(input logic [3:0] i);
    case (i)
      4'd0, 4'd1, 4'd2: init_cmd = 9'h130;
      4'd3:             init_cmd = 9'h120;
      4'd4:             init_cmd = 9'h028;
      4'd5:             init_cmd = 9'h00C;
      4'd6:             init_cmd = 9'h006;
      4'd7:             init_cmd = 9'h001;
      default:          init_cmd = 9'h002;
    endcase
  endfunction

  assign cur_char = txt_b_q ? TEXT_B[(COLS-1-int'(col))*8 +: 8]
                            : TEXT_A[(COLS-1-int'(col))*8 +: 8];
  assign issuing  = (st == S_INIT) || (st == S_ADDR) || (st == S_CHAR) || (st == S_CLR);
  assign wr_start = issuing && (ph == P_GO);

  always_comb begin
    wr_byte  = 8'h00;
    wr_rs    = 1'b0;
    wr_nib   = 1'b0;
    exec_len = CW'(CMD_CYC - 1);
    case (st)
      S_INIT: begin
        {wr_nib, wr_byte} = init_cmd(step);
        if (step >= 4'd7) exec_len = CW'(LONG_CYC - 1);
      end
      S_ADDR: wr_byte = row2_q ? 8'hC0 : 8'h80;
      S_CHAR: begin
        wr_byte = cur_char;
        wr_rs   = 1'b1;
      end
      S_CLR: begin
        wr_byte  = 8'h01;
        exec_len = CW'(LONG_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_PWR;
      ph      <= P_GO;
      cnt     <= CW'(PWRUP_CYC - 1);
      step    <= '0;
      col     <= '0;
      row2_q  <= 1'b0;
      txt_b_q <= 1'b0;
    end else begin
      case (st)
        S_PWR: begin
          if (cnt == '0) begin
            st   <= S_INIT;
            step <= '0;
            ph   <= P_GO;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_IDLE: begin
          ph <= P_GO;
          if (btn_clear) begin
            st <= S_CLR;
          end else if (btn_write) begin
            st      <= S_ADDR;
            row2_q  <= sel_row2;
            txt_b_q <= sel_text;
          end
        end
        default: begin
          case (ph)
            P_GO: ph <= P_ACK;
            P_ACK: begin
              if (wr_done) begin
                ph  <= P_EXEC;
                cnt <= exec_len;
              end
            end
            default: begin
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else begin
                ph <= P_GO;
                case (st)
                  S_INIT: begin
                    if (step == LAST_INIT) st <= S_IDLE;
                    else step <= step + 1'b1;
                  end
                  S_ADDR: begin
                    st  <= S_CHAR;
                    col <= '0;
                  end
                  S_CHAR: begin
                    if (col == COLW'(COLS - 1)) st <= S_IDLE;
                    else col <= col + 1'b1;
                  end
                  default: st <= S_IDLE;
                endcase
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int PWRUP_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_start,
  input logic       wr_done,
  input logic [7:0] wr_byte,
  input logic       wr_rs,
  input logic       wr_nib,
  input logic [1:0] ph
);
  int unsigned since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 0;
    else if (since_rst < 32'hFFFF_FFF0) since_rst <= since_rst + 1;
  end

  // R1: no command before the power-up wait has elapsed
  a_r1_no_early_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (since_rst >= PWRUP_CYC));

  // R7: start is a single-cycle pulse
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  // R7: request fields held while the engine works
  a_r7_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd1) |-> $stable({wr_byte, wr_rs, wr_nib}));

  // R7: no new request while done is still being awaited
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd1 && !wr_done) |=> !wr_start);

  // R2: single-nibble writes are commands with an empty low nibble
  a_r2_nibble_form: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && wr_nib) |-> (!wr_rs && wr_byte[3:0] == 4'h0));

  // R4: character writes are full bytes
  a_r4_data_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && wr_rs) |-> !wr_nib);
endmodule

bind lcd_seq lcd_seq_chk #(.PWRUP_CYC(PWRUP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_done(wr_done),
  .wr_byte(wr_byte), .wr_rs(wr_rs), .wr_nib(wr_nib), .ph(ph)
);

// File: tb/lcd_seq_tb_top.sv
module lcd_seq_tb_top;
  localparam int PW = 40, CM = 3, LG = 9, COLS = 16;
  localparam logic [127:0] TA = "Hello, row one!!";
  localparam logic [127:0] TB = "0123456789ABCDEF";

  logic clk = 0, rst_n = 0;
  logic btn_clear = 0, btn_write = 0, sel_row2 = 0, sel_text = 0, wr_done = 0;
  logic wr_start, wr_rs, wr_nib;
  logic [7:0] wr_byte;
  int cyc = 0, done_cyc = 0, n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_seq #(.PWRUP_CYC(PW), .CMD_CYC(CM), .LONG_CYC(LG), .COLS(COLS),
            .TEXT_A(TA), .TEXT_B(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_clear(btn_clear), .btn_write(btn_write),
    .sel_row2(sel_row2), .sel_text(sel_text), .wr_done(wr_done),
    .wr_start(wr_start), .wr_byte(wr_byte), .wr_rs(wr_rs), .wr_nib(wr_nib));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Waits for a request, records it, answers with done two cycles later.
  task automatic get(output logic [7:0] b, output logic rs, output logic nb,
                     output int gap, input string req);
    int w = 0;
    while (!wr_start && w < 3000) begin @(negedge clk); w++; end
    if (!wr_start) begin
      chk(0, {req, " request timeout"}, 0, 1);
      b = 8'hxx; rs = 0; nb = 0; gap = -1;
      return;
    end
    b = wr_byte; rs = wr_rs; nb = wr_nib; gap = cyc - done_cyc;
    @(negedge clk);
    @(negedge clk);
    wr_done = 1; done_cyc = cyc;
    @(negedge clk);
    wr_done = 0;
  endtask

  task automatic quiet(input int k, input string req);
    bit seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (wr_start) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  function automatic logic [7:0] ch(input bit tb, input int c);
    logic [127:0] s = tb ? TB : TA;
    return 8'((s >> (8 * (COLS - 1 - c))) & 128'hFF);
  endfunction

  // Row write: expects address then sixteen characters.
  task automatic row_seq(input bit r, input bit t, input int addr_gap, input bit poke);
    logic [7:0] b; logic rs, nb; int gap;
    get(b, rs, nb, gap, "R4");
    chk(b == (r ? 8'hC0 : 8'h80) && !rs && !nb, "R4/R5 address command", {rs, nb, b}, r ? 8'hC0 : 8'h80);
    if (addr_gap >= 0) chk(gap == addr_gap, "R6 long wait before next command", gap, addr_gap);
    btn_write = 0;
    for (int c = 0; c < COLS; c++) begin
      if (poke && c == 2) begin
        btn_clear = 1; btn_write = 1;
        @(negedge clk);
        btn_clear = 0; btn_write = 0;
      end
      get(b, rs, nb, gap, "R4");
      chk(b == ch(t, c) && rs && !nb, "R4/R5 character", {rs, nb, b}, {2'b10, ch(t, c)});
      chk(gap == CM + 1, "R3 data wait", gap, CM + 1);
    end
    quiet(25, "R4/R8 back to idle with no extra command");
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-chain actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b; logic rs, nb; int gap;
    logic [8:0] ini [9] = '{9'h130, 9'h130, 9'h130, 9'h120, 9'h028, 9'h00C, 9'h006, 9'h001, 9'h002};

    // R1: held in reset, nothing requested
    quiet(6, "R1 no request during reset");
    @(negedge clk);
    rst_n = 1; done_cyc = cyc;

    // R2 / R3: init sequence and waits
    for (int i = 0; i < 9; i++) begin
      int exp_gap;
      get(b, rs, nb, gap, "R2");
      chk({nb, b} == ini[i] && !rs, "R2 init command", {rs, nb, b}, ini[i]);
      if (i == 0) exp_gap = PW;
      else exp_gap = ((ini[i-1][7:0] == 8'h01 || ini[i-1][7:0] == 8'h02) ? LG : CM) + 1;
      chk(gap == exp_gap, i == 0 ? "R1 power-up wait" : "R3 execution wait", gap, exp_gap);
    end
    quiet(LG + 8, "R2 rests in idle after init");

    // R7: stray done while idle
    wr_done = 1; @(negedge clk); wr_done = 0;
    quiet(20, "R7 stray done ignored");

    // R4 / R5: all row and string combinations, selections flipped after acceptance
    for (int r = 0; r < 2; r++)
      for (int t = 0; t < 2; t++) begin
        sel_row2 = r[0]; sel_text = t[0];
        btn_write = 1;
        @(negedge clk);
        btn_write = 0; sel_row2 = ~r[0]; sel_text = ~t[0];
        row_seq(r[0], t[0], -1, (r == 1 && t == 0));
      end

    // R6: both buttons together, clear wins
    btn_clear = 1; btn_write = 1;
    @(negedge clk);
    btn_clear = 0; btn_write = 0;
    get(b, rs, nb, gap, "R6");
    chk(b == 8'h01 && !rs && !nb, "R6 clear command", {rs, nb, b}, 8'h01);
    quiet(LG + 8, "R6 clear has priority, no row write");

    // R6: long wait after clear, measured with the write button held
    btn_clear = 1;
    @(negedge clk);
    btn_clear = 0;
    get(b, rs, nb, gap, "R6");
    chk(b == 8'h01 && !rs && !nb, "R6 clear command", {rs, nb, b}, 8'h01);
    sel_row2 = 0; sel_text = 1;
    btn_write = 1;
    row_seq(1'b0, 1'b1, LG + 2, 1'b0);

    // R9: reset in the middle of a row write
    sel_row2 = 1; sel_text = 0;
    btn_write = 1;
    @(negedge clk);
    btn_write = 0;
    get(b, rs, nb, gap, "R9");
    for (int c = 0; c < 3; c++) get(b, rs, nb, gap, "R9");
    rst_n = 0;
    quiet(4, "R9 no request during reset");
    rst_n = 1; done_cyc = cyc;
    get(b, rs, nb, gap, "R9");
    chk({nb, b} == 9'h130 && !rs, "R9 restarts with first init nibble", {rs, nb, b}, 9'h130);
    chk(gap == PW, "R9 restarts the power-up wait", gap, PW);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule